// File: doc/BRIEF.md
# Multidrop Serial Receive Channel

This block is one receive lane of an asynchronous serial port. It watches a single serial input and counts time in a clock-enable pulse that runs at sixteen times the bit rate. Each character is framed by a low start bit, eight data bits sent least significant bit first, an optional ninth bit and a high stop bit. Finished characters go into an eight-entry queue. Every queue entry carries its own error flags and an address mark.

The ninth bit is used in one of two ways. In normal mode it is a parity bit, and a mismatch raises a parity error. In multidrop mode it marks address characters. Addressed nodes use this to find the start of a message meant for them.

Error status can be reported in two ways. In character mode it is the status of the character at the head of the queue. In block mode it is a sticky OR of every character that has reached the head since the last clear. The receiver can be disabled without losing what it holds, or reset, which empties the queue.

Top module: `addr_rx_channel`

## Requirements
- R1: A falling input opens a start check. The start is confirmed only if the input is still low on the 8th `tick16` pulse counted from the pulse that saw it low. Otherwise the receiver returns to idle and nothing is stored.
- R2: Every bit lasts 16 `tick16` pulses and is sampled at its centre. Data arrives least significant bit first into `rd_data[7:0]`. A ninth bit is present when `cfg_par_en` or `cfg_multidrop` is 1. The stop bit is sampled once, at its centre.
- R3: Characters are read in arrival order from a queue of 8. `rdy` is 1 while the queue holds at least one character and `full` is 1 while it holds 8. A `rd_stb` pulse removes the head character.
- R4: In normal mode with `cfg_par_en`=1, a ninth bit that leaves the total number of ones among the data bits and the ninth bit odd (when `cfg_par_odd`=0) or even (when `cfg_par_odd`=1) marks the character with a parity error.
- R5: A low stop sample marks the character with a framing error. The character is still stored.
- R6: A frame that is low throughout (data, ninth bit if present, and stop) is stored once as 0x00 with both break and framing flags set, and no parity flag. Nothing further is received until the input has returned high.
- R7: In multidrop mode a ninth bit of 1 sets `rd_addr_flag` for that character, a ninth bit of 0 leaves it clear, and no parity error is ever flagged.
- R8: A character that completes while the queue holds 8 and no read happens in that cycle is dropped and sets `err_overrun`. If a read happens in the same cycle the character is kept. `err_overrun` stays set until `cmd_clr_err` or `cmd_reset`.
- R9: With `cfg_block_err`=0, `err_parity`, `err_frame` and `err_break` show the flags of the head character, and all three are 0 while the queue is empty.
- R10: With `cfg_block_err`=1, the three error outputs are the OR of the flags of every character that has reached the head since the last `cmd_clr_err` or `cmd_reset`. They stay set after that character is read.
- R11: `cmd_disable` stops reception of new characters and abandons a character in progress. Characters already queued stay readable. `cmd_enable` resumes reception.
- R12: `cmd_reset` discards all queued characters, clears overrun and accumulated status, and leaves the receiver disabled.
- R13: `rd_stb` while the queue is empty has no effect. A later character is stored and read back correctly.
- R14: After `rst_n` the receiver is disabled, the queue is empty and every status output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input, idle high |
| cfg_par_en | input | 1 | Ninth bit is a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_multidrop | input | 1 | Ninth bit is an address mark |
| cfg_block_err | input | 1 | 1 selects accumulated error reporting |
| cmd_enable | input | 1 | Pulse: start receiving |
| cmd_disable | input | 1 | Pulse: stop receiving, keep queue |
| cmd_reset | input | 1 | Pulse: flush queue and status, disable |
| cmd_clr_err | input | 1 | Pulse: clear overrun and accumulated flags |
| rd_stb | input | 1 | Pulse: remove the head character |
| rd_data | output | 8 | Head character, 0 when empty |
| rd_addr_flag | output | 1 | Head character is an address |
| rdy | output | 1 | Queue not empty |
| full | output | 1 | Queue holds 8 characters |
| err_parity | output | 1 | Parity error status |
| err_frame | output | 1 | Framing error status |
| err_break | output | 1 | Break status |
| err_overrun | output | 1 | Sticky overrun |

## Verification
The case that needs care is a character finishing its stop bit in the same cycle that the CPU reads from a full queue. In that cycle the push and the pop must both take effect, and no overrun may be raised. The bench fills the queue and runs the bit timing with a pulse every clock. It then counts from the start-bit edge to the stop-bit centre and places a single read strobe on exactly that edge. It judges the result by checking that `err_overrun` stays clear, that `full` is still 1, and that the new character comes out last and in order.

// File: rtl/addr_rx_pkg.sv
package addr_rx_pkg;
  localparam int DATA_W = 8;
  localparam int OSR    = 16;
  localparam int NFLAG  = 3;

  typedef struct packed {
    logic              addr;
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_NINTH = 3'd3,
    RX_STOP  = 3'd4,
    RX_BRKW  = 3'd5
  } rx_state_e;
endpackage

// File: rtl/addr_rx_sampler.sv
module addr_rx_sampler
  import addr_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rxd,
  input  logic     rx_en,
  input  logic     par_en,
  input  logic     par_odd,
  input  logic     multidrop,
  output logic     push,
  output rx_char_t push_char
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  logic [1:0]        sync_q;
  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              ninth_q, ninth_d;
  logic              rx_s, has9, line_break;

  assign rx_s = sync_q[1];
  assign has9 = par_en | multidrop;

  // two-stage input synchronizer, line idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  // frame content seen at the stop-bit centre
  assign line_break = (shift_q == '0) && !(has9 && ninth_q) && !rx_s;

  always_comb begin
    push_char.data = shift_q;
    push_char.frm  = !rx_s;
    push_char.brk  = line_break;
    push_char.addr = multidrop & ninth_q;
    push_char.par  = par_en & !multidrop & !line_break &
                     (((^shift_q) ^ ninth_q) != par_odd);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    ninth_d = ninth_q;
    push    = 1'b0;
    if (!rx_en) begin
      state_d = RX_IDLE;
    end else if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!rx_s) begin
            state_d = RX_START;
            cnt_d   = CNT_W'(1);
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            if (!rx_s) begin
              state_d = RX_DATA;
              cnt_d   = '0;
              idx_d   = '0;
              ninth_d = 1'b0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        RX_DATA: begin
          if (cnt_q == END_CNT) begin
            shift_d = {rx_s, shift_q[DATA_W-1:1]};
            cnt_d   = '0;
            if (idx_q == LAST_IDX) state_d = has9 ? RX_NINTH : RX_STOP;
            else                   idx_d   = idx_q + IDX_W'(1);
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        RX_NINTH: begin
          if (cnt_q == END_CNT) begin
            ninth_d = rx_s;
            cnt_d   = '0;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        RX_STOP: begin
          if (cnt_q == END_CNT) begin
            push    = 1'b1;
            cnt_d   = '0;
            state_d = line_break ? RX_BRKW : RX_IDLE;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        RX_BRKW: begin
          if (rx_s) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      ninth_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      ninth_q <= ninth_d;
    end
  end
endmodule

// File: rtl/addr_rx_fifo.sv
module addr_rx_fifo
  import addr_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     push,
  input  rx_char_t push_char,
  input  logic     pop_req,
  output rx_char_t head,
  output logic     empty,
  output logic     full,
  output logic     overflow,
  output logic     arrive,
  output rx_char_t arrive_char
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rx_char_t          mem [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop_ok, accept;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == FULL_CNT);
  assign head     = mem[rd_q];
  assign pop_ok   = pop_req & !empty & !flush;
  assign accept   = push & (!full | pop_ok) & !flush;
  assign overflow = push & full & !pop_ok & !flush;

  // which character becomes the new head this cycle
  always_comb begin
    arrive      = 1'b0;
    arrive_char = push_char;
    if (empty && accept) begin
      arrive = 1'b1;
    end else if (pop_ok && (cnt_q > CNT_W'(1))) begin
      arrive      = 1'b1;
      arrive_char = mem[bump(rd_q)];
    end else if (pop_ok && accept) begin
      arrive = 1'b1;
    end
  end

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (pop_ok) rd_d = bump(rd_q);
      if (accept) wr_d = bump(wr_q);
      cnt_d = cnt_q + CNT_W'(accept) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  // storage array carries no reset
  always_ff @(posedge clk) begin
    if (accept) mem[wr_q] <= push_char;
  end
endmodule

// File: rtl/addr_rx_status.sv
module addr_rx_status
  import addr_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             clr,
  input  logic             block,
  input  logic             overflow,
  input  logic             arrive,
  input  logic [NFLAG-1:0] arrive_flags,
  input  logic             head_valid,
  input  logic [NFLAG-1:0] head_flags,
  output logic [NFLAG-1:0] err_flags,
  output logic             ovr
);
  logic [NFLAG-1:0] acc_q, acc_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    acc_d = (flush | clr) ? '0 : acc_q;
    if (arrive) acc_d = acc_d | arrive_flags;
    ovr_d = ((flush | clr) ? 1'b0 : ovr_q) | overflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovr_q <= ovr_d;
    end
  end

  assign err_flags = block ? acc_q : (head_valid ? head_flags : '0);
  assign ovr       = ovr_q;
endmodule

// File: rtl/addr_rx_channel.sv
module addr_rx_channel
  import addr_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_multidrop,
  input  logic              cfg_block_err,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_reset,
  input  logic              cmd_clr_err,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_addr_flag,
  output logic              rdy,
  output logic              full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_break,
  output logic              err_overrun
);
  logic [1:0]       rst_sync_q;
  logic             rst_i_n;
  logic             rx_en_q, rx_en_d;
  logic             push, empty, overflow, arrive;
  rx_char_t         push_char, head, arrive_char;
  logic [NFLAG-1:0] err_flags;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_comb begin
    rx_en_d = rx_en_q;
    if (cmd_reset || cmd_disable) rx_en_d = 1'b0;
    else if (cmd_enable)          rx_en_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rx_en_q <= 1'b0;
    else          rx_en_q <= rx_en_d;
  end

  addr_rx_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .tick      (tick16),
    .rxd       (rxd),
    .rx_en     (rx_en_q),
    .par_en    (cfg_par_en),
    .par_odd   (cfg_par_odd),
    .multidrop (cfg_multidrop),
    .push      (push),
    .push_char (push_char)
  );

  addr_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .flush       (cmd_reset),
    .push        (push),
    .push_char   (push_char),
    .pop_req     (rd_stb),
    .head        (head),
    .empty       (empty),
    .full        (full),
    .overflow    (overflow),
    .arrive      (arrive),
    .arrive_char (arrive_char)
  );

  addr_rx_status u_status (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .flush        (cmd_reset),
    .clr          (cmd_clr_err),
    .block        (cfg_block_err),
    .overflow     (overflow),
    .arrive       (arrive),
    .arrive_flags ({arrive_char.brk, arrive_char.frm, arrive_char.par}),
    .head_valid   (!empty),
    .head_flags   ({head.brk, head.frm, head.par}),
    .err_flags    (err_flags),
    .ovr          (err_overrun)
  );

  assign rdy          = !empty;
  assign rd_data      = empty ? '0 : head.data;
  assign rd_addr_flag = !empty & head.addr;
  assign err_break    = err_flags[2];
  assign err_frame    = err_flags[1];
  assign err_parity   = err_flags[0];
endmodule

// File: rtl/addr_rx_checker.sv
module addr_rx_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_stb,
  input logic cmd_reset,
  input logic cmd_disable,
  input logic cmd_clr_err,
  input logic cfg_block_err,
  input logic rdy,
  input logic full,
  input logic err_parity,
  input logic err_frame,
  input logic err_break,
  input logic err_overrun
);
  p_full_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> rdy);

  p_drain_by_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> ($past(rd_stb) || $past(cmd_reset)));

  p_overrun_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(full));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_overrun) |-> ($past(cmd_clr_err) || $past(cmd_reset)));

  p_empty_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_block_err && !rdy) |-> !(err_parity || err_frame || err_break));

  p_block_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_block_err && $past(cfg_block_err) && $past(err_parity) &&
     !$past(cmd_clr_err) && !$past(cmd_reset)) |-> err_parity);

  p_disable_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_disable) && $past(rdy) && !$past(rd_stb) && !$past(cmd_reset)) |-> rdy);

  p_reset_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_reset) |-> (!rdy && !err_overrun));
endmodule

bind addr_rx_channel addr_rx_checker u_chk (.*);

// File: tb/addr_rx_channel_test.sv
module addr_rx_channel_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tick16, rxd;
  logic cfg_par_en, cfg_par_odd, cfg_multidrop, cfg_block_err;
  logic cmd_enable, cmd_disable, cmd_reset, cmd_clr_err, rd_stb;
  logic [7:0] rd_data;
  logic rd_addr_flag, rdy, full, err_parity, err_frame, err_break, err_overrun;

  int tdiv = 1;
  int dcnt = 0;
  always @(posedge clk) dcnt <= (dcnt + 1 >= tdiv) ? 0 : dcnt + 1;
  assign tick16 = (dcnt == 0);

  addr_rx_channel uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_multidrop(cfg_multidrop), .cfg_block_err(cfg_block_err),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_reset(cmd_reset), .cmd_clr_err(cmd_clr_err), .rd_stb(rd_stb),
    .rd_data(rd_data), .rd_addr_flag(rd_addr_flag), .rdy(rdy), .full(full),
    .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
    .err_overrun(err_overrun)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] expq[$];   // {addr, brk, frm, par, data}

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic cmd(input int k);
    @(negedge clk);
    case (k)
      0: cmd_enable  = 1'b1;
      1: cmd_disable = 1'b1;
      2: cmd_reset   = 1'b1;
      3: cmd_clr_err = 1'b1;
      default: rd_stb = 1'b1;
    endcase
    @(negedge clk);
    {cmd_enable, cmd_disable, cmd_reset, cmd_clr_err, rd_stb} = '0;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // driver: serialises one frame and records the expected queue entry
  task automatic send(input logic [7:0] d, input bit has9, input bit b9,
                      input bit stop_bad, input bit keep, input logic [3:0] fl);
    int bt;
    bt = 16 * tdiv;
    if (keep) expq.push_back({fl, d});
    @(negedge clk);
    hold(1'b0, bt);
    for (int i = 0; i < 8; i++) hold(d[i], bt);
    if (has9) hold(b9, bt);
    if (stop_bad) begin
      hold(1'b0, bt / 2);
      hold(1'b1, bt / 2);
    end else begin
      hold(1'b1, bt);
    end
    hold(1'b1, 4);
  endtask

  // monitor: compares the head against the scoreboard, then pops it
  task automatic read_chk(input string req, input bit with_flags);
    logic [11:0] e;
    @(negedge clk);
    if (expq.size() == 0) begin
      checks++; errors++;
      $display("FAIL %s actual=read expected=empty scoreboard", req);
    end else begin
      e = expq.pop_front();
      chk(req, {8'h0, rd_data}, {8'h0, e[7:0]});
      chk(req, {15'h0, rd_addr_flag}, {15'h0, e[11]});
      if (with_flags)
        chk(req, {13'h0, err_break, err_frame, err_parity}, {13'h0, e[10:8]});
    end
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1;
    {cfg_par_en, cfg_par_odd, cfg_multidrop, cfg_block_err} = '0;
    {cmd_enable, cmd_disable, cmd_reset, cmd_clr_err, rd_stb} = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R14 reset state
    chk("R14 status", {10'h0, rdy, full, err_parity, err_frame, err_break, err_overrun}, 16'h0);
    chk("R14 data", {8'h0, rd_data}, 16'h0);

    // R12 receiver starts disabled: frame is ignored
    send(8'h5A, 0, 0, 0, 0, 4'h0);
    chk("R12 disabled after reset", {15'h0, rdy}, 16'h0);
    cmd(0);

    // R2 R3 basic frames with a sparse enable pulse
    tdiv = 2;
    repeat (4) @(negedge clk);
    send(8'hA5, 0, 0, 0, 1, 4'h0);
    send(8'h3C, 0, 0, 0, 1, 4'h0);
    chk("R3 rdy set", {15'h0, rdy}, 16'h1);
    read_chk("R2 first", 1);
    read_chk("R2 second", 1);
    chk("R3 rdy clear", {15'h0, rdy}, 16'h0);
    tdiv = 1;
    repeat (4) @(negedge clk);

    // R1 false start
    @(negedge clk);
    hold(1'b0, 5);
    hold(1'b1, 60);
    chk("R1 false start", {15'h0, rdy}, 16'h0);
    send(8'h81, 0, 0, 0, 1, 4'h0);
    read_chk("R1 after glitch", 1);

    // R4 R9 parity in normal mode
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h55, 1, 0, 0, 1, 4'h0);
    send(8'h07, 1, 0, 0, 1, 4'h1);
    read_chk("R4 even good", 1);
    read_chk("R4 R9 even bad", 1);
    cfg_par_odd = 1'b1;
    send(8'h07, 1, 0, 0, 1, 4'h0);
    send(8'h07, 1, 1, 0, 1, 4'h1);
    read_chk("R4 odd good", 1);
    read_chk("R4 odd bad", 1);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // R5 framing
    send(8'h3F, 0, 0, 1, 1, 4'h2);
    read_chk("R5 framing", 1);
    chk("R9 empty flags", {13'h0, err_break, err_frame, err_parity}, 16'h0);

    // R6 break
    @(negedge clk);
    expq.push_back({4'h6, 8'h00});
    hold(1'b0, 16 * 14);
    chk("R6 break stored", {15'h0, rdy}, 16'h1);
    hold(1'b1, 40);
    read_chk("R6 break", 1);
    chk("R6 single entry", {15'h0, rdy}, 16'h0);

    // R7 multidrop address mark
    cfg_multidrop = 1'b1;
    send(8'h42, 1, 1, 0, 1, 4'h8);
    send(8'h42, 1, 0, 0, 1, 4'h0);
    cfg_par_en = 1'b1;
    send(8'h03, 1, 1, 0, 1, 4'h8);
    read_chk("R7 address", 1);
    read_chk("R7 data", 1);
    read_chk("R7 no parity error", 1);
    cfg_multidrop = 1'b0; cfg_par_en = 1'b0;

    // R8 R3 overrun when full
    for (int i = 0; i < 8; i++) send(8'h10 + 8'(i), 0, 0, 0, 1, 4'h0);
    chk("R3 full", {15'h0, full}, 16'h1);
    send(8'hEE, 0, 0, 0, 0, 4'h0);
    chk("R8 overrun set", {15'h0, err_overrun}, 16'h1);
    for (int i = 0; i < 8; i++) read_chk("R3 R8 order", 1);
    chk("R8 overrun sticky", {15'h0, err_overrun}, 16'h1);
    cmd(3);
    chk("R8 overrun cleared", {15'h0, err_overrun}, 16'h0);

    // R8 completion and read in the same cycle at full
    for (int i = 0; i < 8; i++) send(8'h20 + 8'(i), 0, 0, 0, 1, 4'h0);
    fork
      send(8'h99, 0, 0, 0, 1, 4'h0);
      begin
        @(negedge clk);
        repeat (153) @(posedge clk);
        read_chk("R8 concurrent read", 1);
      end
    join
    chk("R8 no overrun on concurrent read", {15'h0, err_overrun}, 16'h0);
    chk("R8 still full", {15'h0, full}, 16'h1);
    for (int i = 0; i < 8; i++) read_chk("R8 kept char", 1);

    // R10 block mode accumulation
    cfg_block_err = 1'b1; cfg_par_en = 1'b1;
    send(8'h07, 1, 0, 0, 1, 4'h1);
    send(8'h55, 1, 0, 0, 1, 4'h0);
    chk("R10 parity seen", {15'h0, err_parity}, 16'h1);
    read_chk("R10 first", 0);
    chk("R10 held after read", {15'h0, err_parity}, 16'h1);
    @(negedge clk); cfg_block_err = 1'b0;
    @(negedge clk);
    chk("R9 head flags", {15'h0, err_parity}, 16'h0);
    cfg_block_err = 1'b1;
    @(negedge clk);
    chk("R10 accumulation kept", {15'h0, err_parity}, 16'h1);
    cmd(3);
    chk("R10 cleared", {15'h0, err_parity}, 16'h0);
    read_chk("R10 second", 0);
    cfg_block_err = 1'b0; cfg_par_en = 1'b0;

    // R11 disable keeps data
    send(8'h61, 0, 0, 0, 1, 4'h0);
    send(8'h62, 0, 0, 0, 1, 4'h0);
    cmd(1);
    send(8'h63, 0, 0, 0, 0, 4'h0);
    read_chk("R11 kept one", 1);
    read_chk("R11 kept two", 1);
    chk("R11 nothing new", {15'h0, rdy}, 16'h0);
    cmd(0);
    send(8'h64, 0, 0, 0, 1, 4'h0);
    read_chk("R11 resumed", 1);

    // R12 R13 reset flushes, empty read ignored
    send(8'h71, 0, 0, 0, 0, 4'h0);
    send(8'h72, 0, 0, 0, 0, 4'h0);
    cmd(2);
    chk("R12 flushed", {15'h0, rdy}, 16'h0);
    send(8'h7A, 0, 0, 0, 0, 4'h0);
    chk("R12 left disabled", {15'h0, rdy}, 16'h0);
    cmd(4);
    chk("R13 empty read", {14'h0, rdy, full}, 16'h0);
    cmd(0);
    send(8'h73, 0, 0, 0, 1, 4'h0);
    read_chk("R13 after empty read", 1);
    chk("R13 drained", {15'h0, rdy}, 16'h0);

    repeat (10) @(negedge clk);
    report();
  end
endmodule